// File: doc/BRIEF.md
# Counter Self-Test Sequencer

This block is an on-chip test sequencer for a loadable up/down binary counter of parameterised width. It does not walk the counter through its whole state space. It runs a short, fixed series of load-and-step probes instead. Each probe targets one known weak spot: the longest carry path, the longest borrow path, or the falling edge of one individual bit. The whole series takes a number of cycles that grows linearly with the width.

The sequencer drives the load strobe, the load data, the count enable and the count direction of the counter. It reads the counter's value back and compares it with the value it expects. A start pulse launches the series. Once the series ends, `done` goes high and stays high. At that point `pass` or `fail` reports the verdict. A failure is also flagged the cycle after the first wrong value is seen, so a tester can abort early.

Top module: `ctr_bist`

## Requirements
- R1: While reset is active and after its release, `done`, `pass`, `fail`, `cut_load`, `cut_en` and `cut_up` are all 0 until a start is accepted.
- R2: A start is accepted only while idle or while `done` is high. In the cycle after the accepting edge, `cut_load` is 1 and `cut_data` holds the value with bit W-1 at 0 and all lower bits at 1.
- R3: In the next cycle the sequencer raises `cut_en` with `cut_up`=1. One cycle later it expects the read-back value to have only bit W-1 set (full carry).
- R4: In that same cycle, the sequencer raises `cut_en` with `cut_up`=0 to step down from the all-carry result. In the following cycle it expects bit W-1 at 0 with all lower bits at 1 (full borrow).
- R5: The sequencer then handles each bit i, from 0 up to W-1, in a slot of 4 cycles: a load of the value with only bit i set, then a down step, then a compare against 2^i-1, then one idle cycle.
- R6: `done` rises exactly 4W+3 clock edges after the edge that accepted start, stays 1 until the next accepted start, and is 0 while the series runs.
- R7: `fail` rises in the cycle after the first compare that mismatches. It stays 1 until an accepted start clears it.
- R8: `pass` equals `done` with no mismatch recorded. `pass` and `fail` are never 1 together.
- R9: A start pulse while the series is running has no effect on the drive pattern or on the cycle at which `done` rises.
- R10: `cut_load` and `cut_en` are never 1 together, and `cut_up` is 1 only together with `cut_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse for the test series |
| cut_q | input | W | Value read back from the counter under test |
| cut_load | output | 1 | Parallel load strobe to the counter |
| cut_data | output | W | Parallel load value |
| cut_en | output | 1 | Count enable to the counter |
| cut_up | output | 1 | Count direction, 1 = up, 0 = down |
| done | output | 1 | Test series finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | A mismatch has been recorded |

## Verification
A sequencer phase that is skipped, repeated or out of order shows up on the counter drive lines in the very cycle it happens. It appears as a load, enable, direction or data value that differs from the fixed schedule. A wrong expected value or a lost compare shows up one cycle after the compare, through `fail`, or fails to show up there. A slip in the bit index or in the slot length moves the rise of `done` away from edge 4W+3. The bench checks the drive lines in every cycle, the exact cycle in which `fail` rises for three kinds of injected counter fault, and the exact cycle in which `done` rises.

// File: rtl/ctr_bist_pkg.sv
// Shared types for the counter self-test sequencer.
// Assumes nothing beyond a single clock domain.
package ctr_bist_pkg;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CLOAD,   // load MSB=0, lower ones
        PH_CUP,     // step up across full carry chain
        PH_CCHK,    // compare carry result, step down across borrow chain
        PH_BLOAD,   // load single-bit pattern (slot 0 also checks borrow)
        PH_BSTEP,   // step down
        PH_BCHK,    // compare single-bit result
        PH_BSPARE,  // idle slot filler, advance bit index
        PH_DONE
    } phase_t;

endpackage

// File: rtl/ctr_bist_seq.sv
// Phase sequencer: walks the fixed probe schedule once per accepted start.
// Assumes start is synchronous to clk; start outside idle/done is dropped.
module ctr_bist_seq
    import ctr_bist_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output phase_t               phase,
    output logic [$clog2(W)-1:0] idx,
    output logic                 accept
);
    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] LAST = IW'(W - 1);

    // Accept a start only when no series is in flight.
    always_comb accept = start && (phase == PH_IDLE || phase == PH_DONE);

    // Advance through the phases and the per-bit slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: begin
                    if (accept) begin
                        phase <= PH_CLOAD;
                        idx   <= '0;
                    end
                end
                PH_CLOAD:  phase <= PH_CUP;
                PH_CUP:    phase <= PH_CCHK;
                PH_CCHK:   phase <= PH_BLOAD;
                PH_BLOAD:  phase <= PH_BSTEP;
                PH_BSTEP:  phase <= PH_BCHK;
                PH_BCHK:   phase <= PH_BSPARE;
                PH_BSPARE: begin
                    if (idx == LAST) begin
                        phase <= PH_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        phase <= PH_BLOAD;
                    end
                end
                default:   phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ctr_bist_pat.sv
// Pattern decoder: maps phase and bit index to counter drive and expected value.
// Purely combinational; assumes the counter registers its result on the next edge.
module ctr_bist_pat
    import ctr_bist_pkg::*;
#(
    parameter int W = 8
) (
    input  phase_t               phase,
    input  logic [$clog2(W)-1:0] idx,
    output logic                 load,
    output logic [W-1:0]         data,
    output logic                 en,
    output logic                 up,
    output logic                 chk,
    output logic [W-1:0]         expect_val
);
    localparam logic [W-1:0] MSB_ONLY  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] LOW_ONES  = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE       = W'(1);

    logic [W-1:0] bit_pat;

    // One-hot pattern for the current bit slot.
    always_comb bit_pat = ONE << idx;

    // Decode drive, compare strobe and expected read-back per phase.
    always_comb begin
        load       = 1'b0;
        data       = '0;
        en         = 1'b0;
        up         = 1'b0;
        chk        = 1'b0;
        expect_val = '0;
        case (phase)
            PH_CLOAD: begin
                load = 1'b1;
                data = LOW_ONES;
            end
            PH_CUP: begin
                en = 1'b1;
                up = 1'b1;
            end
            PH_CCHK: begin
                en         = 1'b1;
                chk        = 1'b1;
                expect_val = MSB_ONLY;
            end
            PH_BLOAD: begin
                load       = 1'b1;
                data       = bit_pat;
                chk        = (idx == '0);
                expect_val = LOW_ONES;
            end
            PH_BSTEP: en = 1'b1;
            PH_BCHK: begin
                chk        = 1'b1;
                expect_val = bit_pat - ONE;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctr_bist_verdict.sv
// Verdict tracker: latches any compare mismatch and forms done/pass/fail.
// Assumes accept and chk never refer to the same cycle's compare.
module ctr_bist_verdict #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic         chk,
    input  logic [W-1:0] expect_val,
    input  logic [W-1:0] cut_q,
    input  logic         at_end,
    output logic         done,
    output logic         pass,
    output logic         fail
);
    logic mism;

    // Sticky mismatch flag, cleared when a new series begins.
    always_ff @(posedge clk) begin
        if (!rst_n)              mism <= 1'b0;
        else if (accept)         mism <= 1'b0;
        else if (chk && (cut_q != expect_val)) mism <= 1'b1;
    end

    // Status outputs derived from the phase and the flag.
    always_comb begin
        done = at_end;
        pass = at_end && !mism;
        fail = mism;
    end

endmodule

// File: rtl/ctr_bist.sv
// Counter self-test sequencer top: runs carry, borrow and per-bit probes
// against an external loadable up/down counter in 4W+3 cycles.
// Assumes the counter applies load/enable on the next rising edge and that
// load has priority; W is at least 2.
module ctr_bist
    import ctr_bist_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] cut_q,
    output logic         cut_load,
    output logic [W-1:0] cut_data,
    output logic         cut_en,
    output logic         cut_up,
    output logic         done,
    output logic         pass,
    output logic         fail
);
    localparam int IW = $clog2(W);

    phase_t          phase;
    logic [IW-1:0]   idx;
    logic            accept;
    logic            chk;
    logic [W-1:0]    expect_val;

    ctr_bist_seq #(.W(W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phase  (phase),
        .idx    (idx),
        .accept (accept)
    );

    ctr_bist_pat #(.W(W)) u_pat (
        .phase      (phase),
        .idx        (idx),
        .load       (cut_load),
        .data       (cut_data),
        .en         (cut_en),
        .up         (cut_up),
        .chk        (chk),
        .expect_val (expect_val)
    );

    ctr_bist_verdict #(.W(W)) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .chk        (chk),
        .expect_val (expect_val),
        .cut_q      (cut_q),
        .at_end     (phase == PH_DONE),
        .done       (done),
        .pass       (pass),
        .fail       (fail)
    );

endmodule

// File: rtl/ctr_bist_chk.sv
// Port-level property checker for ctr_bist, attached by bind below.
module ctr_bist_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] cut_q,
    input logic         cut_load,
    input logic [W-1:0] cut_data,
    input logic         cut_en,
    input logic         cut_up,
    input logic         done,
    input logic         pass,
    input logic         fail
);
    // R10
    load_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cut_load && cut_en));

    // R10
    up_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cut_up |-> cut_en);

    // R8
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R8
    pass_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R2
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (cut_load && !done && !fail));

    // R3
    load_then_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_load && cut_data == {1'b0, {(W-1){1'b1}}} && W > 2) |=> (cut_en && cut_up));

endmodule

bind ctr_bist ctr_bist_chk #(.W(W)) u_chk (.*);

// File: tb/ctr_bist_test.sv
// Directed bench for ctr_bist with a fault-injectable counter model.
module ctr_bist_test;
    localparam int W   = 8;
    localparam int TOT = 4 * W + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] cut_q;
    logic         cut_load, cut_en, cut_up;
    logic [W-1:0] cut_data;
    logic         done, pass, fail;

    int n_tests = 0;
    int n_fail  = 0;
    logic finished = 1'b0;

    // 0 none, 1 bit2 cannot fall on down count, 2 no carry into MSB, 3 no borrow into MSB
    int fault_mode = 0;
    logic [W-1:0] cnt_nxt;

    always #2 clk = ~clk;

    ctr_bist #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cut_q(cut_q),
        .cut_load(cut_load), .cut_data(cut_data), .cut_en(cut_en), .cut_up(cut_up),
        .done(done), .pass(pass), .fail(fail)
    );

    // Counter under test, load has priority over count.
    always_comb begin
        cnt_nxt = cut_q;
        if (cut_load) cnt_nxt = cut_data;
        else if (cut_en) begin
            cnt_nxt = cut_up ? cut_q + 1'b1 : cut_q - 1'b1;
            if (fault_mode == 1 && !cut_up && cut_q[2] && !cnt_nxt[2]) cnt_nxt[2] = 1'b1;
            if (fault_mode == 2 && cut_up)  cnt_nxt[W-1] = cut_q[W-1];
            if (fault_mode == 3 && !cut_up) cnt_nxt[W-1] = cut_q[W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cut_q <= '0;
        else        cut_q <= cnt_nxt;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive schedule expected n edges after the accepting edge (R2..R5).
    task automatic exp_ctl(input int n, output logic ld, output logic en, output logic up,
                           output logic [W-1:0] d);
        ld = 1'b0; en = 1'b0; up = 1'b0; d = '0;
        if (n == 0) begin ld = 1'b1; d = {1'b0, {(W-1){1'b1}}}; end
        else if (n == 1) begin en = 1'b1; up = 1'b1; end
        else if (n == 2) en = 1'b1;
        else if (n < TOT) begin
            if ((n - 3) % 4 == 0) begin ld = 1'b1; d = W'(1) << ((n - 3) / 4); end
            else if ((n - 3) % 4 == 1) en = 1'b1;
        end
    endtask

    // R1: quiet outputs after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({done, pass, fail, cut_load, cut_en, cut_up} == 6'b0, "R1 in reset",
              32'({done, pass, fail, cut_load, cut_en, cut_up}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({done, pass, fail, cut_load, cut_en, cut_up} == 6'b0, "R1 after reset",
              32'({done, pass, fail, cut_load, cut_en, cut_up}), 0);
    endtask

    // One full series: schedule, fail timing (R7), done timing (R6), verdict (R8), R9.
    task automatic t_run(input int fmode, input int fail_at, input int extra_start, input string name);
        logic ld, en, up;
        logic [W-1:0] d;
        int first_fail;
        fault_mode = fmode;
        first_fail = -1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int n = 0; n <= TOT; n++) begin
            if (n > 0) @(negedge clk);
            start = (n == extra_start);
            if (fail && first_fail < 0) first_fail = n;
            if (n < TOT) begin
                exp_ctl(n, ld, en, up, d);
                check({cut_load, cut_en, cut_up} == {ld, en, up} && cut_data == d,
                      (n == 0) ? "R2 first load" : (n == 1) ? "R3 carry step" :
                      (n == 2) ? "R4 borrow step" : (extra_start >= 0) ? "R9 schedule" : "R5 bit slot",
                      32'({cut_load, cut_en, cut_up, cut_data}), 32'({ld, en, up, d}));
                if (done) check(1'b0, "R6 early done", n, TOT);
            end
        end
        start = 1'b0;
        check(done == 1'b1, (extra_start >= 0) ? "R9 done at 4W+3" : "R6 done at 4W+3", 32'(done), 1);
        check(first_fail == fail_at, {"R7 fail timing ", name}, first_fail, fail_at);
        check(pass == (fail_at < 0) && fail == (fail_at >= 0), {"R8 verdict ", name},
              32'({pass, fail}), 32'({fail_at < 0, fail_at >= 0}));
        repeat (4) @(negedge clk);
        check(done && pass == (fail_at < 0), "R6 done holds", 32'({done, pass}), 32'({1'b1, fail_at < 0}));
    endtask

    initial begin
        t_reset();
        t_run(0, -1, -1, "good");
        t_run(1, 14, -1, "bit2 stuck high on down");
        t_run(2, 3,  -1, "carry broken");
        t_run(3, 4,  -1, "borrow broken");
        t_run(0, -1, 10, "restart clears and mid-run start ignored");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R6 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule